// File: doc/BRIEF.md
# NAND Invalid-Block Table Scanner

This block runs on the host side of an 8-bit NAND flash device. After a start pulse, it walks through every erase block of the device in ascending order and reads one marker byte from each of the first two pages of that block. The result is kept in an internal one-bit-per-block table: a set bit means the block is unusable. When the walk is complete, the block raises a single-cycle done pulse. The table can then be read through a combinational lookup port, so that mapping logic elsewhere can skip bad blocks.

Each page access is one chip-enable window with the following steps:

- a read command byte;
- three address bytes: the column, the low row byte and the high row byte;
- a wait for the device's ready/busy line to go high;
- a single read strobe, during which the marker byte is captured.

The low and high times of the write and read strobes come from four cycle-count inputs. A device that never becomes ready does not stall the scan. A timeout gives up on that block, marks it bad and moves on.

Top module: `nand_bbt_scanner`

## Requirements
- R1: After reset, chip enable (active low), write strobe and read strobe are high, command latch and address latch are low, done is low, and every table entry reads 0.
- R2: Each page read sends command byte 00h with command latch high, then three bytes with address latch high: the column MARK_COL[7:0], row[7:0], and {3'b000, row[12:8]}, where row = block*16 + page. Pages 0 and 1 of each block are read, and blocks are visited in order from 0 to NUM_BLOCKS-1.
- R3: A read strobe falls only after ready/busy has been seen high. Each page that does not time out gets exactly one read strobe.
- R4: A block other than block 0 is marked bad (table bit 1) when the byte captured on page 0 or on page 1 is not FFh. It is marked good (bit 0) when both bytes are FFh.
- R5: Block 0 always reads as good, whatever marker bytes or timeouts it has.
- R6: If ready/busy stays low for TIMEOUT cycles in one wait, the block is marked bad (except block 0). No further page of that block is read, and the scan continues with the next block.
- R7: Every write strobe is low for max(we_lo_cyc,1) cycles. Write strobes within one page are high for max(we_hi_cyc,1) cycles between them. The read strobe is low for max(re_lo_cyc,1) cycles and is followed by max(re_hi_cyc,1) cycles before chip enable rises. Strobes occur only while chip enable is low, and chip enable goes high for at least one cycle between page reads.
- R8: A start pulse in idle clears the whole table before scanning begins. After the last block, done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan (taken in idle only) |
| done | output | 1 | One-cycle pulse when the scan ends |
| we_lo_cyc | input | STRB_W | Write strobe low cycles (0 acts as 1) |
| we_hi_cyc | input | STRB_W | Write strobe high cycles (0 acts as 1) |
| re_lo_cyc | input | STRB_W | Read strobe low cycles (0 acts as 1) |
| re_hi_cyc | input | STRB_W | Cycles after read strobe before chip enable rises (0 acts as 1) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_oe | output | 1 | Drive enable for the data bus |
| nand_dq_out | output | 8 | Command and address bytes |
| nand_dq_in | input | 8 | Data from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |
| tbl_idx | input | log2(NUM_BLOCKS) | Table lookup block index |
| tbl_bad | output | 1 | 1 when the indexed block is marked bad |

## Verification
The bench runs three complete 512-block scans against a behavioural device model. Each scan uses a different marker-byte pattern and a different set of strobe widths:

- **All-FFh scan.** An all-FFh device must give an empty table. This separates real marker detection from stray sampling of the bus outside the strobe.
- **Modular-pattern scan.** A modular pattern puts 00h or single-bit-off bytes on page 0 only, on page 1 only, on block 0 and on the last block. This tells apart the first-page check, the second-page check, the block 0 override and the end-of-range handling.
- **Timeout scan.** A third pattern leaves the device busy forever on chosen pages. This shows whether a timeout both marks the block and skips its second page, which the model sees in the order of row addresses.

The model also times every strobe and every chip-enable gap against the configured counts.

// File: rtl/nand_bbt_scanner.sv
module nand_bbt_scanner #(
  parameter int NUM_BLOCKS      = 512,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int MARK_COL        = 0,
  parameter int STRB_W          = 4,
  parameter int TIMEOUT         = 20000
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic                          done,
  input  logic [STRB_W-1:0]             we_lo_cyc,
  input  logic [STRB_W-1:0]             we_hi_cyc,
  input  logic [STRB_W-1:0]             re_lo_cyc,
  input  logic [STRB_W-1:0]             re_hi_cyc,
  output logic                          nand_ce_n,
  output logic                          nand_cle,
  output logic                          nand_ale,
  output logic                          nand_we_n,
  output logic                          nand_re_n,
  output logic                          nand_dq_oe,
  output logic [7:0]                    nand_dq_out,
  input  logic [7:0]                    nand_dq_in,
  input  logic                          nand_rb,
  input  logic [$clog2(NUM_BLOCKS)-1:0] tbl_idx,
  output logic                          tbl_bad
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK);
  localparam int ROW_W = BLK_W + PG_W;
  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WLO, S_WHI, S_WAIT, S_RLO, S_RHI, S_NEXT
  } state_t;

  state_t                st;
  logic [BLK_W-1:0]      blk;
  logic                  pg;
  logic                  blk_end;
  logic [1:0]            idx;
  logic [STRB_W-1:0]     tcnt;
  logic [STRB_W-1:0]     cur_lim;
  logic [TMO_W-1:0]      tmo;
  logic [NUM_BLOCKS-1:0] bad_q;
  logic                  tick_end;
  logic [ROW_W-1:0]      row;
  logic [15:0]           row_ext;

  assign row     = {blk, {(PG_W-1){1'b0}}, pg};
  assign row_ext = 16'(row);

  always_comb begin
    case (st)
      S_WLO:   cur_lim = we_lo_cyc;
      S_WHI:   cur_lim = we_hi_cyc;
      S_RLO:   cur_lim = re_lo_cyc;
      S_RHI:   cur_lim = re_hi_cyc;
      default: cur_lim = '0;
    endcase
    if (cur_lim == '0) cur_lim = STRB_W'(1);
  end
  assign tick_end = (tcnt >= cur_lim - STRB_W'(1));

  assign nand_ce_n  = (st == S_IDLE) || (st == S_NEXT);
  assign nand_dq_oe = (st == S_WLO) || (st == S_WHI);
  assign nand_cle   = nand_dq_oe && (idx == 2'd0);
  assign nand_ale   = nand_dq_oe && (idx != 2'd0);
  assign nand_we_n  = (st != S_WLO);
  assign nand_re_n  = (st != S_RLO);

  always_comb begin
    case (idx)
      2'd0:    nand_dq_out = 8'h00;
      2'd1:    nand_dq_out = 8'(MARK_COL);
      2'd2:    nand_dq_out = row_ext[7:0];
      default: nand_dq_out = row_ext[15:8];
    endcase
  end

  assign tbl_bad = (tbl_idx != '0) && bad_q[tbl_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      blk     <= '0;
      pg      <= 1'b0;
      blk_end <= 1'b0;
      idx     <= '0;
      tcnt    <= '0;
      tmo     <= '0;
      bad_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          bad_q <= '0;
          blk   <= '0;
          pg    <= 1'b0;
          st    <= S_SETUP;
        end
        S_SETUP: begin
          idx     <= '0;
          tcnt    <= '0;
          blk_end <= 1'b0;
          st      <= S_WLO;
        end
        S_WLO: begin
          if (tick_end) begin
            tcnt <= '0;
            st   <= S_WHI;
          end else tcnt <= tcnt + STRB_W'(1);
        end
        S_WHI: begin
          if (tick_end) begin
            tcnt <= '0;
            if (idx == 2'd3) begin
              tmo <= '0;
              st  <= S_WAIT;
            end else begin
              idx <= idx + 2'd1;
              st  <= S_WLO;
            end
          end else tcnt <= tcnt + STRB_W'(1);
        end
        S_WAIT: begin
          if (nand_rb) begin
            tcnt <= '0;
            st   <= S_RLO;
          end else if (tmo == TMO_LAST) begin
            if (blk != '0) bad_q[blk] <= 1'b1;
            blk_end <= 1'b1;
            st      <= S_NEXT;
          end else tmo <= tmo + TMO_W'(1);
        end
        S_RLO: begin
          if (tick_end) begin
            if (nand_dq_in != 8'hFF && blk != '0) bad_q[blk] <= 1'b1;
            tcnt <= '0;
            st   <= S_RHI;
          end else tcnt <= tcnt + STRB_W'(1);
        end
        S_RHI: begin
          if (tick_end) begin
            blk_end <= pg;
            tcnt    <= '0;
            st      <= S_NEXT;
          end else tcnt <= tcnt + STRB_W'(1);
        end
        S_NEXT: begin
          if (!blk_end) begin
            pg <= 1'b1;
            st <= S_SETUP;
          end else if (blk == LAST_BLK) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            blk <= blk + BLK_W'(1);
            pg  <= 1'b0;
            st  <= S_SETUP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_inside_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_ce_gap_before_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_cle) |-> $past(nand_ce_n, 2));

  assert_read_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> $past(nand_rb));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_last_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (blk == LAST_BLK));
endmodule

// File: tb/sim_nand_bbt_scanner.sv
module sim_nand_bbt_scanner;
  localparam int NB   = 512;
  localparam int TMO  = 64;
  localparam int MARK = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic [3:0] we_lo, we_hi, re_lo, re_hi;
  logic ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0] dq_out, dq_in;
  logic rb = 1'b1;
  logic [8:0] tbl_idx = '0;
  logic tbl_bad;

  always #2 clk = ~clk;

  nand_bbt_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(16), .MARK_COL(MARK),
                     .STRB_W(4), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .we_lo_cyc(we_lo), .we_hi_cyc(we_hi), .re_lo_cyc(re_lo), .re_hi_cyc(re_hi),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
    .nand_re_n(re_n), .nand_dq_oe(dq_oe), .nand_dq_out(dq_out), .nand_dq_in(dq_in),
    .nand_rb(rb), .tbl_idx(tbl_idx), .tbl_bad(tbl_bad));

  int total = 0;
  int bad = 0;
  int scan_id = 0;

  function automatic int lim(logic [3:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  function automatic logic [7:0] mark_of(int s, int b, int p);
    if (s == 1) begin
      if (p == 0 && (b % 7 == 3 || b == 0)) return 8'h00;
      if (p == 0 && b % 13 == 1) return 8'hFE;
      if (p == 1 && (b % 11 == 5 || b == NB - 1)) return 8'h00;
    end
    if (s == 2 && p == 0 && b % 9 == 4) return 8'h7F;
    return 8'hFF;
  endfunction

  function automatic bit stuck_of(int s, int b, int p);
    if (s != 2) return 1'b0;
    if (p == 1 && b % 50 == 17) return 1'b1;
    if (p == 0 && (b % 97 == 40 || b == 0)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_bad(int s, int b);
    if (b == 0) return 1'b0;
    if (stuck_of(s, b, 0) || mark_of(s, b, 0) != 8'hFF) return 1'b1;
    return stuck_of(s, b, 1) || mark_of(s, b, 1) != 8'hFF;
  endfunction

  // device model, evaluated on the falling clock edge
  logic [7:0] cur_byte = 8'hFF;
  assign dq_in = re_n ? 8'h00 : cur_byte;

  int acnt = 0, exp_b = 0, exp_p = 0, busy_left = 0;
  int we_w = 0, hi_w = 0, re_w = 0, rh_w = 0, strobes = 0;
  int addr_err = 0, width_err = 0, rd_err = 0, proto_err = 0;
  bit stuck = 0, in_page = 0, ce_hi_seen = 1, rh_track = 0, cur_stuck = 0, first = 1;
  logic prev_we = 1, prev_re = 1;
  logic [7:0] ab [3];

  always @(negedge clk) begin
    if (start) begin
      exp_b = 0; exp_p = 0; first = 1; addr_err = 0; width_err = 0;
      rd_err = 0; proto_err = 0; strobes = 0; cur_stuck = 0;
    end
    if (ce_n) ce_hi_seen = 1;
    if ((!we_n || !re_n) && ce_n) proto_err++;
    if (!we_n) begin
      if (prev_we && in_page && hi_w != lim(we_hi)) width_err++;
      we_w++;
    end else if (!prev_we) begin
      if (we_w != lim(we_lo)) width_err++;
      we_w = 0;
      hi_w = 1;
      if (cle) begin
        if (!first && strobes != (cur_stuck ? 0 : 1)) rd_err++;
        if (!ce_hi_seen) proto_err++;
        first = 0; ce_hi_seen = 0; strobes = 0;
        acnt = 0; in_page = 1; stuck = 0; rb = 1;
        if (dq_out != 8'h00) addr_err++;
      end else if (ale) begin
        ab[acnt] = dq_out;
        acnt++;
        if (acnt == 3) begin
          in_page = 0;
          if (ab[0] != 8'(MARK) || ab[2][7:5] != 3'b000) addr_err++;
          if (int'({ab[2], ab[1]}) != exp_b * 16 + exp_p) addr_err++;
          cur_stuck = stuck_of(scan_id, exp_b, exp_p);
          stuck = cur_stuck;
          cur_byte = mark_of(scan_id, exp_b, exp_p);
          busy_left = 1 + (exp_b * 3 + exp_p) % 5;
          rb = 0;
          if (cur_stuck || exp_p == 1) begin exp_b++; exp_p = 0; end
          else exp_p = 1;
        end
      end
    end else if (in_page) hi_w++;
    if (!re_n) begin
      if (prev_re) begin
        strobes++;
        if (!rb) rd_err++;
      end
      re_w++;
    end else if (!prev_re) begin
      if (re_w != lim(re_lo)) width_err++;
      re_w = 0; rh_track = 1; rh_w = 1;
    end else if (rh_track) begin
      if (ce_n) begin
        if (rh_w != lim(re_hi)) width_err++;
        rh_track = 0;
      end else rh_w++;
    end
    if (!rb && !stuck) begin
      if (busy_left == 0) rb = 1;
      else busy_left--;
    end
    prev_we = we_n;
    prev_re = re_n;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_scan(input int s, input logic [3:0] wl, input logic [3:0] wh,
                          input logic [3:0] rl, input logic [3:0] rh);
    int cyc;
    scan_id = s;
    we_lo = wl; we_hi = wh; re_lo = rl; re_hi = rh;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    tbl_idx = 9'd3; #1;
    chk(tbl_bad == 1'b0, "R8", "table cleared by start", tbl_bad, 0);
    tbl_idx = 9'd5; #1;
    chk(tbl_bad == 1'b0, "R8", "table cleared by start", tbl_bad, 0);
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R8", "done reached", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    chk(exp_b == NB, "R2", "blocks visited in order", exp_b, NB);
    chk(addr_err == 0, "R2", "command/address byte errors", addr_err, 0);
    chk(rd_err == 0, "R3", "strobe before ready or wrong strobe count", rd_err, 0);
    chk(width_err == 0, "R7", "strobe width errors", width_err, 0);
    chk(proto_err == 0, "R7", "chip enable errors", proto_err, 0);
    for (int b = 0; b < NB; b++) begin
      tbl_idx = 9'(b); #1;
      if (b == 0)
        chk(tbl_bad == 1'b0, "R5", $sformatf("scan %0d block 0", s), tbl_bad, 0);
      else if (stuck_of(s, b, 0) || stuck_of(s, b, 1))
        chk(tbl_bad == exp_bad(s, b), "R6", $sformatf("scan %0d block %0d", s, b), tbl_bad, exp_bad(s, b));
      else
        chk(tbl_bad == exp_bad(s, b), "R4", $sformatf("scan %0d block %0d", s, b), tbl_bad, exp_bad(s, b));
    end
  endtask

  initial begin
    we_lo = 4'd1; we_hi = 4'd1; re_lo = 4'd1; re_hi = 4'd1;
    repeat (4) @(negedge clk);
    chk(ce_n == 1'b1 && we_n == 1'b1 && re_n == 1'b1, "R1", "strobes idle after reset",
        {ce_n, we_n, re_n}, 7);
    chk(cle == 1'b0 && ale == 1'b0 && done == 1'b0, "R1", "latches and done low after reset",
        {cle, ale, done}, 0);
    begin
      int ones = 0;
      for (int b = 0; b < NB; b++) begin tbl_idx = 9'(b); #1; ones += int'(tbl_bad); end
      chk(ones == 0, "R1", "table empty after reset", ones, 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_scan(0, 4'd1, 4'd1, 4'd1, 4'd1);
    run_scan(1, 4'd2, 4'd3, 4'd1, 4'd2);
    run_scan(2, 4'd0, 4'd2, 4'd3, 4'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule